// File: doc/BRIEF.md
# Serial Number Update Sequencer

This block rewrites a 64-bit device serial number while the device is running. The serial number normally lives in read-only capability registers. To change it, the block first sets a write-enable bit in a control register, then writes the new value, and then clears the bit again. All of this goes through a memory-mapped register port. The host gives one start pulse together with the low and high 32-bit halves of the new number. It then waits for `done`, and it checks `error` if it needs to know whether the update went through.

The register port carries full 32-bit accesses with no byte enables. A master command (`reg_rd` or `reg_wr`) stays asserted and unchanged until a cycle in which `reg_stall` is low; that cycle accepts it. After a read is accepted, the data comes back later, in a cycle where `reg_rvalid` is high.

The sequence changes only one bit of the control register, the write-enable bit. Every other bit is written back exactly as it was read. The register is read again before relocking, so any bit that changed during the update is kept.

The state machine has these states:

| State | Action | Leaves to |
|---|---|---|
| ST_IDLE | waits for a start pulse | ST_UL_RD on start |
| ST_UL_RD | issues a read of the control register | ST_UL_WAIT when accepted |
| ST_UL_WAIT | waits for the read data | ST_UL_WR on data; ST_RL_RD on timeout |
| ST_UL_WR | writes the control register with the write-enable bit set | ST_SN_LO when accepted |
| ST_SN_LO | writes the low half of the serial number | ST_SN_HI when accepted |
| ST_SN_HI | writes the high half of the serial number | ST_RL_RD when accepted |
| ST_RL_RD | issues a fresh read of the control register | ST_RL_WAIT when accepted |
| ST_RL_WAIT | waits for the read data | ST_RL_WR on data; ST_IDLE on timeout |
| ST_RL_WR | writes the control register with the write-enable bit cleared | ST_IDLE when accepted |

Top module: `sn_update_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the block in ST_IDLE. In the cycle after `rst` is sampled high, `busy`, `done`, `error`, `reg_rd` and `reg_wr` are all low, even if an update was in progress.
- R2: A start pulse seen while idle does two things: it stores `sn_lo` and `sn_hi`, and it raises `busy` on the next cycle. A start pulse seen while `busy` is high is ignored. It does not change the stored words, the accesses that follow, or the number of `done` pulses.
- R3: The first access of a sequence is a read of the control register at address 0x8BC. If that read returns data, the next access is a write to 0x8BC. The write data is the value read with bit 0 forced to 1, and all other bits unchanged.
- R4: On the normal path, exactly six accesses are issued, in this order:
  1. read 0x8BC
  2. write 0x8BC
  3. write `sn_lo` to 0x168
  4. write `sn_hi` to 0x16C
  5. read 0x8BC
  6. write 0x8BC
- R5: The relock write to 0x8BC carries the value returned by the second read, not the first, with bit 0 cleared and all other bits unchanged.
- R6: While `reg_stall` is high, a pending access holds `reg_addr`, `reg_wdata`, `reg_rd` and `reg_wr` steady. `reg_rd` and `reg_wr` are never high together.
- R7: A read finishes only when `reg_rvalid` arrives. If `reg_rvalid` has not arrived after RD_TIMEOUT wait cycles, `error` rises. A timeout on the first read skips both serial-number writes but still carries out the relock read and write. A timeout on the relock read issues no write and returns to idle.
- R8: When a sequence ends (normally or after an error), `done` is high for exactly one cycle, and `busy` falls in that same cycle. `error` stays set until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse from the host |
| sn_lo | input | DATA_W | Low half (first dword) of the new serial number |
| sn_hi | input | DATA_W | High half (second dword) of the new serial number |
| busy | output | 1 | High while a sequence runs |
| done | output | 1 | One-cycle pulse when a sequence ends |
| error | output | 1 | Read timeout seen in the last sequence |
| reg_addr | output | ADDR_W | Register address of the current access |
| reg_wr | output | 1 | Write command |
| reg_rd | output | 1 | Read command |
| reg_wdata | output | DATA_W | Write data |
| reg_rdata | input | DATA_W | Read data |
| reg_rvalid | input | 1 | Read data valid strobe |
| reg_stall | input | 1 | Wait request; the command is held while high |

## Verification
Timing of each result:
- `busy` is due one cycle after the edge that samples `start`.
- Each command appears in the same cycle as its state and is accepted at the first edge where `reg_stall` is low.
- `done` rises, and `busy` falls, one cycle after the relock write is accepted.
- `error` rises one cycle after the RD_TIMEOUT-th wait cycle.

The bench drives and samples every port at the falling clock edge. It uses a responder that stalls each command a set number of cycles and returns read data after a set latency. It compares the whole access log, and the final register contents of the responder, only after `done` has been seen. It checks `done` again on the following falling edge to confirm the one-cycle width.

// File: rtl/sn_seq_pkg.sv
package sn_seq_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UL_RD,
        ST_UL_WAIT,
        ST_UL_WR,
        ST_SN_LO,
        ST_SN_HI,
        ST_RL_RD,
        ST_RL_WAIT,
        ST_RL_WR
    } seq_state_e;
endpackage

// File: rtl/sn_seq_capture.sv
module sn_seq_capture #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] d_lo,
    input  logic [DATA_W-1:0] d_hi,
    output logic [DATA_W-1:0] q_lo,
    output logic [DATA_W-1:0] q_hi
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_lo <= '0;
            q_hi <= '0;
        end else if (load) begin
            q_lo <= d_lo;
            q_hi <= d_hi;
        end
    end
endmodule

// File: rtl/sn_seq_rd_timer.sv
module sn_seq_rd_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST); // R7
endmodule

// File: rtl/sn_seq_fsm.sv
module sn_seq_fsm
    import sn_seq_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                DATA_W    = 32,
    parameter int                LOCK_BIT  = 0,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h8BC,
    parameter logic [ADDR_W-1:0] LO_ADDR   = 'h168,
    parameter logic [ADDR_W-1:0] HI_ADDR   = 'h16C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] sn_lo_q,
    input  logic [DATA_W-1:0] sn_hi_q,
    output logic              accept,
    output logic              tmr_run,
    input  logic              tmr_expired,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_rvalid,
    input  logic              reg_stall
);
    localparam logic [DATA_W-1:0] LOCK_MASK = DATA_W'(1) << LOCK_BIT;

    seq_state_e state, nxt;
    logic [DATA_W-1:0] rd_q;
    logic              done_q, err_q;
    logic              in_wait, timeout;

    assign in_wait = (state == ST_UL_WAIT) || (state == ST_RL_WAIT);
    assign timeout = in_wait && !reg_rvalid && tmr_expired;
    assign accept  = (state == ST_IDLE) && start;
    assign tmr_run = in_wait;
    assign busy    = (state != ST_IDLE);
    assign done    = done_q;
    assign error   = err_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start)       nxt = ST_UL_RD;
            ST_UL_RD:   if (!reg_stall)  nxt = ST_UL_WAIT;
            ST_UL_WAIT: if (reg_rvalid)  nxt = ST_UL_WR;
                        else if (tmr_expired) nxt = ST_RL_RD;
            ST_UL_WR:   if (!reg_stall)  nxt = ST_SN_LO;
            ST_SN_LO:   if (!reg_stall)  nxt = ST_SN_HI;
            ST_SN_HI:   if (!reg_stall)  nxt = ST_RL_RD;
            ST_RL_RD:   if (!reg_stall)  nxt = ST_RL_WAIT;
            ST_RL_WAIT: if (reg_rvalid)  nxt = ST_RL_WR;
                        else if (tmr_expired) nxt = ST_IDLE;
            ST_RL_WR:   if (!reg_stall)  nxt = ST_IDLE;
            default:                     nxt = ST_IDLE;
        endcase
    end

    // captured read value, done pulse and sticky error
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q   <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (in_wait && reg_rvalid) rd_q <= reg_rdata;
            done_q <= ((state == ST_RL_WR) && !reg_stall) ||
                      ((state == ST_RL_WAIT) && timeout);
            if (accept)       err_q <= 1'b0;
            else if (timeout) err_q <= 1'b1;
        end
    end

    // port outputs
    always_comb begin
        reg_addr  = CTRL_ADDR;
        reg_wr    = 1'b0;
        reg_rd    = 1'b0;
        reg_wdata = '0;
        unique case (state)
            ST_UL_RD, ST_RL_RD: reg_rd = 1'b1;
            ST_UL_WR: begin
                reg_wr    = 1'b1;
                reg_wdata = rd_q | LOCK_MASK;
            end
            ST_SN_LO: begin
                reg_wr    = 1'b1;
                reg_addr  = LO_ADDR;
                reg_wdata = sn_lo_q;
            end
            ST_SN_HI: begin
                reg_wr    = 1'b1;
                reg_addr  = HI_ADDR;
                reg_wdata = sn_hi_q;
            end
            ST_RL_WR: begin
                reg_wr    = 1'b1;
                reg_wdata = rd_q & ~LOCK_MASK;
            end
            default: ;
        endcase
    end

    AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
        (reg_rd || reg_wr) && reg_stall |=>
            $stable(reg_addr) && $stable(reg_wdata) && $stable(reg_rd) && $stable(reg_wr)); // R6
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reg_rd, reg_wr})); // R6
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R8
    AST_ERR_NO_SN: assert property (@(posedge clk) disable iff (rst)
        error |-> !(reg_wr && (reg_addr == LO_ADDR || reg_addr == HI_ADDR))); // R7
endmodule

// File: rtl/sn_update_seq.sv
module sn_update_seq #(
    parameter int                ADDR_W     = 12,
    parameter int                DATA_W     = 32,
    parameter int                RD_TIMEOUT = 16,
    parameter int                LOCK_BIT   = 0,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 'h8BC,
    parameter logic [ADDR_W-1:0] LO_ADDR    = 'h168,
    parameter logic [ADDR_W-1:0] HI_ADDR    = 'h16C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] sn_lo,
    input  logic [DATA_W-1:0] sn_hi,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_rvalid,
    input  logic              reg_stall
);
    logic              accept, tmr_run, tmr_expired;
    logic [DATA_W-1:0] lo_q, hi_q;

    sn_seq_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst(rst), .load(accept),
        .d_lo(sn_lo), .d_hi(sn_hi), .q_lo(lo_q), .q_hi(hi_q)
    );

    sn_seq_rd_timer #(.LIMIT(RD_TIMEOUT)) u_tmr (
        .clk(clk), .rst(rst), .run(tmr_run), .expired(tmr_expired)
    );

    sn_seq_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_BIT(LOCK_BIT),
        .CTRL_ADDR(CTRL_ADDR), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
    ) u_fsm (
        .clk(clk), .rst(rst), .start(start),
        .sn_lo_q(lo_q), .sn_hi_q(hi_q),
        .accept(accept), .tmr_run(tmr_run), .tmr_expired(tmr_expired),
        .busy(busy), .done(done), .error(error),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .reg_stall(reg_stall)
    );
endmodule

// File: tb/sn_update_seq_tb_top.sv
module sn_update_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_CTRL = 12'h8BC;
    localparam logic [11:0] A_LO   = 12'h168;
    localparam logic [11:0] A_HI   = 12'h16C;
    localparam logic [31:0] LO_INIT = 32'hA5A5_0000;
    localparam logic [31:0] HI_INIT = 32'h5A5A_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] sn_lo = '0, sn_hi = '0;
    logic        busy, done, error;
    logic [11:0] reg_addr;
    logic        reg_wr, reg_rd;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata = '0;
    logic        reg_rvalid = 1'b0;
    logic        reg_stall = 1'b0;

    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sn_update_seq #(.RD_TIMEOUT(6)) dut_i (
        .clk(clk), .rst(rst), .start(start), .sn_lo(sn_lo), .sn_hi(sn_hi),
        .busy(busy), .done(done), .error(error),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .reg_stall(reg_stall)
    );

    // responder state
    int          stall_cfg = 0, lat_cfg = 1, stall_n = 0, rd_cd = 0, rd_idx = 0;
    logic [1:0]  drop_mask = '0;
    logic [31:0] ctrl_m = '0, lo_m = '0, hi_m = '0, twist_m = '0, rd_pdata = '0;
    bit          hold_chk = 0;
    logic [11:0] s_addr;
    logic [31:0] s_wdata;
    logic        s_rd, s_wr;
    bit          log_wr[16];
    logic [11:0] log_addr[16];
    logic [31:0] log_data[16];
    int          nlog = 0;
    int          done_cnt = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (done) done_cnt++;
        if (rst) begin
            reg_stall = 0; reg_rvalid = 0; rd_cd = 0; stall_n = 0; hold_chk = 0;
        end else begin
            if (hold_chk)
                chk(s_addr == reg_addr && s_wdata == reg_wdata && s_rd == reg_rd && s_wr == reg_wr,
                    "R6 held command", {reg_rd, reg_wr, 18'd0, reg_addr}, {s_rd, s_wr, 18'd0, s_addr});
            hold_chk = 0;
            reg_rvalid = 0;
            if (rd_cd > 0) begin
                rd_cd--;
                if (rd_cd == 0) begin reg_rvalid = 1; reg_rdata = rd_pdata; end
            end
            if (reg_rd || reg_wr) begin
                if (stall_n < stall_cfg) begin
                    stall_n++; reg_stall = 1; hold_chk = 1;
                    s_addr = reg_addr; s_wdata = reg_wdata; s_rd = reg_rd; s_wr = reg_wr;
                end else begin
                    stall_n = 0; reg_stall = 0;
                    if (nlog < 16) begin
                        log_wr[nlog] = reg_wr; log_addr[nlog] = reg_addr;
                        log_data[nlog] = reg_wr ? reg_wdata : 32'h0;
                        nlog++;
                    end
                    if (reg_wr) begin
                        if (reg_addr == A_CTRL) ctrl_m = reg_wdata;
                        else if (reg_addr == A_LO) lo_m = reg_wdata;
                        else if (reg_addr == A_HI) begin hi_m = reg_wdata; ctrl_m = ctrl_m ^ twist_m; end
                    end else begin
                        if (!(rd_idx < 2 && drop_mask[rd_idx])) begin
                            rd_cd = lat_cfg; rd_pdata = ctrl_m;
                        end
                        rd_idx++;
                    end
                end
            end else begin
                reg_stall = 0; stall_n = 0;
            end
        end
    end

    task automatic run_seq(input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] init,
                           input logic [31:0] tw, input logic [1:0] dm, input bit poke);
        bit          e_wr[8];
        logic [11:0] e_addr[8];
        logic [31:0] e_data[8];
        int          en = 0, n = 0;
        logic [31:0] c, fc, exp_lo, exp_hi;
        ctrl_m = init; lo_m = LO_INIT; hi_m = HI_INIT; twist_m = tw;
        drop_mask = dm; rd_idx = 0; nlog = 0; done_cnt = 0;
        @(negedge clk); start = 1; sn_lo = lo; sn_hi = hi;
        @(negedge clk); start = 0;
        chk(busy == 1, "R2 busy after start", 32'(busy), 1);
        chk(error == 0, "R8 error cleared by start", 32'(error), 0);
        if (poke) begin
            start = 1; sn_lo = ~lo; sn_hi = ~hi;
            @(negedge clk); @(negedge clk); start = 0;
        end
        while (!done && n < 500) begin @(negedge clk); n++; end
        chk(n < 500, "R8 done reached", n, 0);
        chk(busy == 0, "R8 busy low with done", 32'(busy), 0);
        @(negedge clk);
        chk(done == 0, "R8 done one cycle", 32'(done), 0);
        repeat (4) @(negedge clk);
        chk(done_cnt == 1 && busy == 0, "R2 single done pulse", done_cnt, 1);

        e_wr[en] = 0; e_addr[en] = A_CTRL; e_data[en] = 0; en++;
        if (!dm[0]) begin
            c = init | 32'h1;
            e_wr[en] = 1; e_addr[en] = A_CTRL; e_data[en] = c;  en++;
            e_wr[en] = 1; e_addr[en] = A_LO;   e_data[en] = lo; en++;
            e_wr[en] = 1; e_addr[en] = A_HI;   e_data[en] = hi; en++;
            c = c ^ tw; exp_lo = lo; exp_hi = hi;
        end else begin
            c = init; exp_lo = LO_INIT; exp_hi = HI_INIT;
        end
        e_wr[en] = 0; e_addr[en] = A_CTRL; e_data[en] = 0; en++;
        if (!dm[1]) begin
            fc = c & ~32'h1;
            e_wr[en] = 1; e_addr[en] = A_CTRL; e_data[en] = fc; en++;
        end else fc = c;

        chk(nlog == en, "R4 access count", nlog, en);
        for (int i = 0; i < en && i < nlog; i++)
            chk(log_wr[i] == e_wr[i] && log_addr[i] == e_addr[i] && log_data[i] == e_data[i],
                "R4 access order/data", {log_wr[i], 7'd0, log_addr[i], 12'd0} ^ log_data[i],
                {e_wr[i], 7'd0, e_addr[i], 12'd0} ^ e_data[i]);
        if (!dm[0] && nlog > 1)
            chk(log_data[1] == (init | 32'h1), "R3 unlock value", log_data[1], init | 32'h1);
        chk(ctrl_m == fc, "R5 control after relock", ctrl_m, fc);
        chk(lo_m == exp_lo && hi_m == exp_hi, "R7 serial words written", lo_m, exp_lo);
        chk(error == (dm != 0), "R7 error flag", 32'(error), 32'(dm != 0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy && !done && !error && !reg_rd && !reg_wr, "R1 reset state",
            {busy, done, error, reg_rd, reg_wr}, 0);
        // sweep of stall, latency and data patterns
        for (int st = 0; st < 3; st++)
            for (int la = 1; la < 4; la++)
                for (int p = 0; p < 3; p++) begin
                    stall_cfg = st; lat_cfg = la;
                    run_seq(32'h1357_9BDF * (p + 1), 32'hFEDC_0123 ^ (32'h0101_0101 << p),
                            (32'h0F0F_00F0 << p) | 32'(p & 1), (p == 1) ? 32'h00F0_0000 : 32'(p * 32'h300),
                            2'b00, 1'b0);
                end
        // read timeouts (R7)
        stall_cfg = 1; lat_cfg = 2;
        run_seq(32'hCAFE_0001, 32'hBEEF_0002, 32'h8000_0010, 32'h0000_0400, 2'b01, 1'b0);
        run_seq(32'hCAFE_0003, 32'hBEEF_0004, 32'h8000_0011, 32'h0000_0400, 2'b10, 1'b0);
        run_seq(32'hCAFE_0005, 32'hBEEF_0006, 32'h8000_0012, 32'h0000_0400, 2'b11, 1'b0);
        // error cleared by next start, start while busy ignored (R2, R8)
        run_seq(32'h0BAD_F00D, 32'h600D_CAFE, 32'h0000_0000, 32'h0, 2'b00, 1'b1);
        // reset in mid sequence (R1)
        @(negedge clk); start = 1; sn_lo = 32'h1; sn_hi = 32'h2;
        @(negedge clk); start = 0;
        repeat (3) @(negedge clk);
        rst = 1;
        @(negedge clk);
        chk(!busy && !done && !error && !reg_rd && !reg_wr, "R1 reset mid sequence",
            {busy, done, error, reg_rd, reg_wr}, 0);
        rst = 0;
        repeat (3) @(negedge clk);
        chk(!busy && !reg_rd && !reg_wr, "R1 idle after reset", {busy, reg_rd, reg_wr}, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule